// File: doc/BRIEF.md
# Interpolation Basepoint Controller

This block steers a cubic Lagrange timing interpolator that is fed with a four-times oversampled stream. It produces one symbol-rate output for every base period of four input clocks. On each of these outputs it adds a signed timing-offset step to the fractional interval `frac_mu`. It then keeps `frac_mu` inside [-0.5, 0.5) by moving the interpolation basepoint whenever the interval leaves that range.

It tests the range with the two top bits of the sum only. If the sum has reached +0.5, one input sample is skipped: the next capture period of the four-deep holding chain grows to five clocks, and 1.0 is taken off the interval. If the sum has fallen below -0.5, one sample is duplicated: the next capture period shrinks to three clocks, and 1.0 is added. The holding-chain load enable, the current basepoint mode and a valid strobe for the filter output are all provided.

A run enable freezes the whole controller, so that it can be parked during guard intervals without losing its phase.

Top module: `interp_basepoint_ctrl`

## Requirements
- R1: While `rst_n` is low, `frac_mu` is 0, `base_mode` is 2'b00 and both `hold_load` and `out_valid` are 0.
- R2: In mode NORMAL (`base_mode` = 2'b00), `hold_load` pulses for one cycle after every fourth enabled clock. After reset, the first pulse follows the fourth enabled edge.
- R3: At each load edge, the new interval is `frac_mu + frac_step` in Q1.15 two's complement, kept unchanged when its top two bits are 00 or 11. The mode then becomes NORMAL.
- R4: When the sum's top two bits are 01 (at or above +0.5), the interval becomes the sum minus 1.0 and `base_mode` becomes SKIP (2'b01). The following load period is five enabled clocks.
- R5: When the sum's top two bits are 10 (below -0.5), the interval becomes the sum plus 1.0 and `base_mode` becomes DUP (2'b10). The following load period is three enabled clocks.
- R6: SKIP and DUP last exactly one load period. `base_mode` changes only together with a `hold_load` pulse.
- R7: `out_valid` pulses exactly one cycle after each `hold_load` pulse, and at no other time.
- R8: While `run_en` is low, the load counter, `frac_mu` and `base_mode` hold their values, and no `hold_load` pulse is produced.
- R9: Provided `frac_step` lies in [-0.5, 0.5), `frac_mu` always lies in [-0.5, 0.5), so its top two bits are equal.
- R10: `frac_step` is used only at load edges. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (4x symbol rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Advance enable; low freezes the controller |
| frac_step | input | MU_W | Signed Q1.15 step added per output |
| frac_mu | output | MU_W | Fractional interval, Q1.15 |
| base_mode | output | 2 | 00 NORMAL, 01 SKIP, 10 DUP |
| hold_load | output | 1 | Capture pulse for the four holding registers |
| out_valid | output | 1 | Interpolated output valid strobe |

## Verification
The main function is driven with a table of steps that cover several cases:
- Small positive steps let the interval drift upward with no wrap.
- Sums exactly at +0.5 and just below -0.5 sit on the two-bit boundaries.
- The step values -0.5 and +0.5-lsb are the extremes of the allowed step range.
- Steps that wrap on two successive outputs show that the period follows the mode of the previous output rather than the current one.

Each vector checks the spacing between load pulses, the wrapped interval and the mode together. A skip followed by a duplicate can therefore be told apart from two normal periods that happen to end on the same interval. A stall that spans a step change, and a reset taken mid-period, show that neither leaks into the phase.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SKIP   = 2'b01,
    MODE_DUP    = 2'b10
  } mode_e;

  // Two-bit range test: 01 means >= +0.5, 10 means < -0.5
  function automatic mode_e range_class(input logic [1:0] top2);
    case (top2)
      2'b01:   return MODE_SKIP;
      2'b10:   return MODE_DUP;
      default: return MODE_NORMAL;
    endcase
  endfunction

  // Load period in enabled clocks for a given basepoint mode
  function automatic int unsigned period_of(input mode_e m, input int unsigned base);
    case (m)
      MODE_SKIP: return base + 1;
      MODE_DUP:  return base - 1;
      default:   return base;
    endcase
  endfunction

endpackage

// File: rtl/ibc_load_timer.sv
module ibc_load_timer
  import ibc_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  mode_e cur_mode,
  output logic  load_edge
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_end;

  always_comb begin
    last_cnt = CNT_W'(period_of(cur_mode, BASE_PERIOD) - 1);
    at_end   = (cnt_q == last_cnt);
  end

  assign load_edge = run_en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_en) begin
      cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ibc_frac_acc.sv
module ibc_frac_acc
  import ibc_pkg::*;
#(
  parameter int unsigned MU_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [MU_W-1:0] step,
  output logic [MU_W-1:0] mu,
  output mode_e           mode,
  output logic            wrap_evt
);

  localparam logic [MU_W-1:0] ONE_UNIT = {1'b1, {(MU_W-1){1'b0}}};

  // Adding or removing 1.0 in Q1.(MU_W-1) is a flip of the sign bit
  function automatic logic [MU_W-1:0] shift_unit(input logic [MU_W-1:0] v);
    return v ^ ONE_UNIT;
  endfunction

  logic [MU_W-1:0] mu_q;
  mode_e           mode_q;
  logic [MU_W-1:0] sum;
  mode_e           nxt_mode;

  always_comb begin
    sum      = mu_q + step;
    nxt_mode = range_class(sum[MU_W-1 -: 2]);
  end

  assign wrap_evt = take && (nxt_mode != MODE_NORMAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mu_q   <= '0;
      mode_q <= MODE_NORMAL;
    end else if (take) begin
      mu_q   <= (nxt_mode == MODE_NORMAL) ? sum : shift_unit(sum);
      mode_q <= nxt_mode;
    end
  end

  assign mu   = mu_q;
  assign mode = mode_q;

endmodule

// File: rtl/interp_basepoint_ctrl.sv
module interp_basepoint_ctrl
  import ibc_pkg::*;
#(
  parameter int unsigned MU_W        = 16,
  parameter int unsigned BASE_PERIOD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_en,
  input  logic [MU_W-1:0] frac_step,
  output logic [MU_W-1:0] frac_mu,
  output logic [1:0]      base_mode,
  output logic            hold_load,
  output logic            out_valid
);

  localparam int unsigned CNT_W = $clog2(BASE_PERIOD + 2);

  mode_e cur_mode;
  logic  load_edge;
  logic  wrap_evt;
  logic  load_q;
  logic  valid_q;

  ibc_load_timer #(
    .BASE_PERIOD(BASE_PERIOD),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .cur_mode (cur_mode),
    .load_edge(load_edge)
  );

  ibc_frac_acc #(
    .MU_W(MU_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (load_edge),
    .step    (frac_step),
    .mu      (frac_mu),
    .mode    (cur_mode),
    .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      load_q  <= load_edge;
      valid_q <= load_q;
    end
  end

  assign base_mode = cur_mode;
  assign hold_load = load_q;
  assign out_valid = valid_q;

endmodule

// File: rtl/ibc_checker.sv
module ibc_checker
  import ibc_pkg::*;
#(
  parameter int unsigned MU_W        = 16,
  parameter int unsigned BASE_PERIOD = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run_en,
  input logic [MU_W-1:0] frac_step,
  input logic [MU_W-1:0] frac_mu,
  input logic [1:0]      base_mode,
  input logic            hold_load,
  input logic            out_valid,
  input logic            wrap_evt
);

  logic [3:0] en_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cnt <= '0;
    end else if (hold_load) begin
      en_cnt <= run_en ? 4'd1 : 4'd0;
    end else if (run_en && en_cnt != 4'hF) begin
      en_cnt <= en_cnt + 4'd1;
    end
  end

  a_r9_mu_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    frac_mu[MU_W-1] == frac_mu[MU_W-2]);

  a_r7_valid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> out_valid);

  a_r7_valid_only_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(hold_load));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!hold_load && $stable(frac_mu) && $stable(base_mode)));

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_load |-> $stable(base_mode));

  a_r2_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |-> (en_cnt == 4'(period_of(mode_e'($past(base_mode)), BASE_PERIOD))));

  a_r3_normal_update: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_load && base_mode == 2'b00) |->
      (frac_mu == MU_W'($past(frac_mu) + $past(frac_step))));

  a_r4_skip_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_load && base_mode == 2'b01) |-> frac_mu[MU_W-1]);

  a_r5_dup_nonnegative: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_load && base_mode == 2'b10) |-> !frac_mu[MU_W-1]);

  a_r6_wrap_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (base_mode != 2'b00));

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    base_mode != 2'b11);

endmodule

bind interp_basepoint_ctrl ibc_checker #(
  .MU_W       (MU_W),
  .BASE_PERIOD(BASE_PERIOD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .frac_step(frac_step),
  .frac_mu  (frac_mu),
  .base_mode(base_mode),
  .hold_load(hold_load),
  .out_valid(out_valid),
  .wrap_evt (wrap_evt)
);

// File: tb/tb_interp_basepoint_ctrl.sv
module tb_interp_basepoint_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MU_W       = 16;
  localparam int NVEC       = 14;

  // step, expected interval, expected mode, expected enabled-clock gap
  localparam int STEP_V [NVEC] = '{4096, 8192, 8192, 2048, -8192, 0, 2048,
                                   0, -1, -16384, 16383, 16383, -16384, 0};
  localparam int MU_V   [NVEC] = '{4096, 12288, -12288, -10240, 14336, 14336, -16384,
                                   -16384, 16383, -1, 16382, -3, 16381, 16381};
  localparam int MODE_V [NVEC] = '{0, 0, 1, 0, 2, 0, 1, 0, 2, 0, 0, 1, 2, 0};
  localparam int GAP_V  [NVEC] = '{4, 4, 4, 5, 4, 3, 4, 5, 4, 3, 4, 4, 5, 3};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            run_en = 1'b1;
  logic [MU_W-1:0] frac_step = '0;
  logic [MU_W-1:0] frac_mu;
  logic [1:0]      base_mode;
  logic            hold_load;
  logic            out_valid;

  int n_checks = 0;
  int n_fails  = 0;

  interp_basepoint_ctrl #(.MU_W(MU_W), .BASE_PERIOD(4)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .frac_step(frac_step),
    .frac_mu  (frac_mu),
    .base_mode(base_mode),
    .hold_load(hold_load),
    .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int mu_val();
    return int'($signed(frac_mu));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Waits for the next load pulse and returns the number of enabled edges seen
  task automatic wait_load(input int start, output int gap);
    gap = start;
    do begin
      tick();
      if (run_en) gap++;
    end while (!hold_load && gap < 20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    int gap;
    // R1: reset state
    frac_step = MU_W'(STEP_V[0]);
    tick();
    tick();
    check("R1 reset mu", mu_val(), 0);
    check("R1 reset mode", int'(base_mode), 0);
    check("R1 reset load", int'(hold_load), 0);
    check("R1 reset valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Main table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      frac_step = MU_W'(STEP_V[i]);
      wait_load((i == 0) ? 0 : 1, gap);
      check($sformatf("R2/R4/R5 gap vec %0d", i), gap, GAP_V[i]);
      check($sformatf("R3 mu vec %0d", i), mu_val(), MU_V[i]);
      check($sformatf("R6 mode vec %0d", i), int'(base_mode), MODE_V[i]);
      check($sformatf("R9 range vec %0d", i), int'(frac_mu[MU_W-1] == frac_mu[MU_W-2]), 1);
      tick();
      check($sformatf("R7 valid vec %0d", i), int'(out_valid), 1);
      check($sformatf("R7 load single vec %0d", i), int'(hold_load), 0);
    end

    // R8: freeze with run_en low, step changed meanwhile
    run_en = 1'b0;
    frac_step = MU_W'(-16384);
    for (int k = 0; k < 8; k++) begin
      tick();
      check("R8 frozen load", int'(hold_load), 0);
      check("R8 frozen mu", mu_val(), 16381);
      check("R8 frozen mode", int'(base_mode), 0);
    end
    check("R8 frozen valid", int'(out_valid), 0);

    // R10: step changes on a non-load edge, only the load-edge value counts
    run_en = 1'b1;
    tick();
    check("R10 no load yet", int'(hold_load), 0);
    frac_step = MU_W'(100);
    wait_load(2, gap);
    check("R8 resumed gap", gap, 4);
    check("R10 mu from load-edge step", mu_val(), -16287);
    check("R4 skip after resume", int'(base_mode), 1);

    // R1: reset taken mid-period
    tick();
    tick();
    rst_n = 1'b0;
    #1;
    check("R1 mid reset mu", mu_val(), 0);
    check("R1 mid reset mode", int'(base_mode), 0);
    check("R1 mid reset load", int'(hold_load), 0);
    frac_step = '0;
    tick();
    @(negedge clk);
    rst_n = 1'b1;
    wait_load(0, gap);
    check("R2 gap after reset", gap, 4);
    check("R3 zero step mu", mu_val(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule